// File: doc/BRIEF.md
# Abstract Register-Access Instruction Generator

This block belongs to a debug module. It turns one abstract register-access command into a short program of 32-bit instruction words and writes it into a small abstract instruction buffer. The halted hart later runs that buffer. A command names a register number, an access size, a transfer bit, a direction bit and a post-execute bit. The block also receives the pending command-error code and a flag that permits access to control and status registers. It writes one buffer slot per clock. At the end it raises a one-cycle `done` strobe and reports the resulting error code.

Register numbers fall into three classes. Integer registers move to and from a fixed data word with a single load or store. Control and status registers pass through `s0`, which is first parked in debug scratch register 0 and restored from there afterwards. Floating-point registers, and the three floating-point control registers, are wrapped in a sequence that keeps the old machine status in debug scratch register 1 and forces the FPU state field on. This lets a debugger reach them even when software has switched the FPU off. The original status is put back when the access is complete. Every program ends with a terminator, either a breakpoint or a jump to the program buffer, and all slots after it are padded with breakpoints.

FSM states: `ST_IDLE` (wait for a command), `ST_PRO` (five-word floating-point prologue), `ST_SAVE` (park `s0`), `ST_XFER` (one or two access words), `ST_REST` (reload `s0`), `ST_EPI` (three-word floating-point epilogue), `ST_TERM` (terminator word), `ST_FILL` (pad with breakpoints), `ST_DONE` (strobe). Transitions: IDLE→DONE on a rejected command, IDLE→TERM when transfer is clear, IDLE→PRO/SAVE/XFER by register class, PRO→XFER after five words, SAVE→XFER, XFER→EPI/REST/TERM by class, REST→TERM, EPI→TERM after three words, TERM/FILL→FILL until the last slot and then →DONE, DONE→IDLE.

Top module: `abs_cmd_gen`

## Requirements
- R1: A command accepted while `err_in` is nonzero produces no buffer write. `done` is high in the next cycle, and `err_out` equals `err_in`.
- R2: With transfer set, a register number of 0x1040 or above, or any number below 0x1000 while `csr_access_en` is 0, yields `err_out` = 2 (not supported) and leaves the buffer unchanged. The numbers 0x001, 0x002 and 0x003 count as registers below 0x1000.
- R3: With transfer set, a size code other than 2 (32-bit) yields `err_out` = 2 and leaves the buffer unchanged.
- R4: Integer register x(n) (number 0x1000+n) is read with `sw xn, 0x380(x0)` and written with `lw xn, 0x380(x0)`.
- R5: A floating-point target (0x1020–0x103F, or 0x001/0x002/0x003) begins with five words in this order: csrrw x0,0x7B2,s0; csrrs s0,0x300,x0; csrrw x0,0x7B3,s0; lui s0,0x6; csrrs x0,0x300,s0.
- R6: After its access, a floating-point target gets csrrs s0,0x7B3,x0; csrrw x0,0x300,s0; csrrs s0,0x7B2,x0. Register f(n) is read with `fsw fn,0x380(x0)` and written with `flw fn,0x380(x0)`.
- R7: A register below 0x1000 that is not floating-point is wrapped by csrrw x0,0x7B2,s0 before the access and csrrs s0,0x7B2,x0 after it. The floating-point control registers get no such extra pair.
- R8: Register access below 0x1000 is encoded as (csr<<20)|(rs1<<15)|(f3<<12)|(rd<<7)|0x73. A read is csrrs s0,csr,x0 followed by `sw s0,0x380(x0)`. A write is `lw s0,0x380(x0)` followed by csrrw x0,csr,s0.
- R9: With transfer clear, register number and size are not examined, and slot 0 holds the terminator.
- R10: The terminator is ebreak (0x00100073), or, with post-execute set, `jal x0` to address 0x300 computed from slot address 0x340+4·slot. Every slot after the terminator holds ebreak.
- R11: An accepted command is followed by exactly 12 slot writes, and then by `done` for exactly one cycle with `err_out` = 0.
- R12: After reset every slot holds ebreak, `done` is 0 and `err_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken only when idle |
| cmd_regno | input | 16 | Register number |
| cmd_size | input | 3 | Access size code (2 = 32-bit) |
| cmd_transfer | input | 1 | Perform the register access |
| cmd_write | input | 1 | 1 = write the register from the data word |
| cmd_postexec | input | 1 | End with a jump to the program buffer |
| err_in | input | 3 | Pending command-error code |
| csr_access_en | input | 1 | Allow access to registers below 0x1000 |
| abuf_words | output | NUM_SLOTS*32 | Instruction buffer, slot i at bits [32i+31:32i] |
| done | output | 1 | One-cycle end-of-command strobe |
| err_out | output | 3 | Resulting command-error code |

## Verification
On every cycle the assertions check three things: that a command rejected by a pending error or by a bad size finishes on the next cycle with the right code, that a rejected command leaves the buffer untouched, and that `done` lasts only one cycle and always follows a terminator in the last slot. The exact instruction sequences can only be shown by the bench scenarios, which compare every slot with a behavioural model. These cover the order of the prologue and epilogue, the choice between the scratch save and the status wrapping, the jump offset per slot, the handling of the floating-point control registers and the rejection of CSR numbers when access is disabled.

// File: rtl/absgen_pkg.sv
package absgen_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRO, ST_SAVE, ST_XFER, ST_REST,
        ST_EPI, ST_TERM, ST_FILL, ST_DONE
    } gen_state_e;

    typedef enum logic [1:0] {RC_GPR, RC_FPR, RC_CSR, RC_BAD} reg_class_e;

    localparam logic [2:0]  ERR_NONE    = 3'd0;
    localparam logic [2:0]  ERR_NOTSUP  = 3'd2;
    localparam logic [2:0]  SIZE_32     = 3'd2;
    localparam logic [11:0] CSR_MSTATUS = 12'h300;
    localparam logic [11:0] CSR_SCR0    = 12'h7B2;
    localparam logic [11:0] CSR_SCR1    = 12'h7B3;
    localparam logic [4:0]  REG_ZERO    = 5'd0;
    localparam logic [4:0]  REG_S0      = 5'd8;
    localparam logic [19:0] FS_UPPER    = 20'h00006;
    localparam logic [2:0]  F3_RW       = 3'b001;
    localparam logic [2:0]  F3_RS       = 3'b010;
    localparam logic [6:0]  OP_LOAD     = 7'h03;
    localparam logic [6:0]  OP_FLOAD    = 7'h07;
    localparam logic [6:0]  OP_STORE    = 7'h23;
    localparam logic [6:0]  OP_FSTORE   = 7'h27;
    localparam logic [31:0] ENC_EBREAK  = 32'h0010_0073;

    function automatic logic [31:0] enc_csr(input logic [2:0] f3, input logic [4:0] rd,
                                            input logic [4:0] rs1, input logic [11:0] csr);
        return {csr, rs1, f3, rd, 7'h73};
    endfunction

    function automatic logic [31:0] enc_lui(input logic [4:0] rd, input logic [19:0] imm);
        return {imm, rd, 7'h37};
    endfunction

    function automatic logic [31:0] enc_load(input logic [6:0] op, input logic [4:0] rd,
                                             input logic [11:0] ofs);
        return {ofs, REG_ZERO, 3'b010, rd, op};
    endfunction

    function automatic logic [31:0] enc_store(input logic [6:0] op, input logic [4:0] src,
                                              input logic [11:0] ofs);
        return {ofs[11:5], src, REG_ZERO, 3'b010, ofs[4:0], op};
    endfunction

    function automatic logic [31:0] enc_jal0(input logic [20:0] ofs);
        return {ofs[20], ofs[10:1], ofs[11], ofs[19:12], REG_ZERO, 7'h6F};
    endfunction

endpackage

// File: rtl/abs_reg_class.sv
module abs_reg_class
    import absgen_pkg::*;
#(
    parameter int REGNO_W = 16
) (
    input  logic [REGNO_W-1:0] regno,
    input  logic               csr_en,
    output reg_class_e         rclass,
    output logic               fp_side,
    output logic [4:0]         idx,
    output logic [11:0]        csr_addr
);
    localparam logic [REGNO_W-1:0] GPR_BASE = REGNO_W'('h1000);
    localparam logic [REGNO_W-1:0] FPR_BASE = REGNO_W'('h1020);
    localparam logic [REGNO_W-1:0] FPR_END  = REGNO_W'('h1040);

    logic is_csr, is_gpr, is_fpr, is_fcsr;

    always_comb begin
        is_csr   = regno < GPR_BASE;
        is_gpr   = (regno >= GPR_BASE) && (regno < FPR_BASE);
        is_fpr   = (regno >= FPR_BASE) && (regno < FPR_END);
        is_fcsr  = is_csr && (regno[11:0] >= 12'h001) && (regno[11:0] <= 12'h003);
        fp_side  = is_fpr || is_fcsr;
        idx      = regno[4:0];
        csr_addr = regno[11:0];
        if (is_gpr)                rclass = RC_GPR;
        else if (is_fpr)           rclass = RC_FPR;
        else if (is_csr && csr_en) rclass = RC_CSR;
        else                       rclass = RC_BAD;
    end
endmodule

// File: rtl/abs_word_sel.sv
module abs_word_sel
    import absgen_pkg::*;
#(
    parameter int          PTR_W     = 4,
    parameter logic [11:0] DATA_OFS  = 12'h380,
    parameter logic [31:0] ABS_ADDR  = 32'h340,
    parameter logic [31:0] PBUF_ADDR = 32'h300
) (
    input  gen_state_e       state,
    input  logic [2:0]       step,
    input  reg_class_e       rclass,
    input  logic             wr,
    input  logic             post,
    input  logic [4:0]       idx,
    input  logic [11:0]      csr_addr,
    input  logic [PTR_W-1:0] slot,
    output logic [31:0]      word
);
    logic [31:0] jump_ofs;

    always_comb begin
        jump_ofs = PBUF_ADDR - (ABS_ADDR + {{(32-PTR_W-2){1'b0}}, slot, 2'b00});
        word     = ENC_EBREAK;
        unique case (state)
            ST_PRO: begin
                unique case (step)
                    3'd0:    word = enc_csr(F3_RW, REG_ZERO, REG_S0, CSR_SCR0);
                    3'd1:    word = enc_csr(F3_RS, REG_S0, REG_ZERO, CSR_MSTATUS);
                    3'd2:    word = enc_csr(F3_RW, REG_ZERO, REG_S0, CSR_SCR1);
                    3'd3:    word = enc_lui(REG_S0, FS_UPPER);
                    default: word = enc_csr(F3_RS, REG_ZERO, REG_S0, CSR_MSTATUS);
                endcase
            end
            ST_SAVE: word = enc_csr(F3_RW, REG_ZERO, REG_S0, CSR_SCR0);
            ST_XFER: begin
                unique case (rclass)
                    RC_GPR: word = wr ? enc_load(OP_LOAD, idx, DATA_OFS)
                                      : enc_store(OP_STORE, idx, DATA_OFS);
                    RC_FPR: word = wr ? enc_load(OP_FLOAD, idx, DATA_OFS)
                                      : enc_store(OP_FSTORE, idx, DATA_OFS);
                    RC_CSR: begin
                        if (step == 3'd0)
                            word = wr ? enc_load(OP_LOAD, REG_S0, DATA_OFS)
                                      : enc_csr(F3_RS, REG_S0, REG_ZERO, csr_addr);
                        else
                            word = wr ? enc_csr(F3_RW, REG_ZERO, REG_S0, csr_addr)
                                      : enc_store(OP_STORE, REG_S0, DATA_OFS);
                    end
                    default: word = ENC_EBREAK;
                endcase
            end
            ST_REST: word = enc_csr(F3_RS, REG_S0, REG_ZERO, CSR_SCR0);
            ST_EPI: begin
                unique case (step)
                    3'd0:    word = enc_csr(F3_RS, REG_S0, REG_ZERO, CSR_SCR1);
                    3'd1:    word = enc_csr(F3_RW, REG_ZERO, REG_S0, CSR_MSTATUS);
                    default: word = enc_csr(F3_RS, REG_S0, REG_ZERO, CSR_SCR0);
                endcase
            end
            ST_TERM: word = post ? enc_jal0(jump_ofs[20:0]) : ENC_EBREAK;
            default: word = ENC_EBREAK;
        endcase
    end
endmodule

// File: rtl/abs_slot_buf.sv
module abs_slot_buf
    import absgen_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int PTR_W     = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [PTR_W-1:0]       wptr,
    input  logic [31:0]            wdata,
    output logic [NUM_SLOTS*32-1:0] words
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [31:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q <= ENC_EBREAK;
            else if (we && (wptr == PTR_W'(g)))
                slot_q <= wdata;
        end
        assign words[g*32 +: 32] = slot_q;
    end
endmodule

// File: rtl/abs_cmd_gen.sv
module abs_cmd_gen
    import absgen_pkg::*;
#(
    parameter int          NUM_SLOTS = 12,
    parameter int          REGNO_W   = 16,
    parameter logic [11:0] DATA_OFS  = 12'h380,
    parameter logic [31:0] ABS_ADDR  = 32'h340,
    parameter logic [31:0] PBUF_ADDR = 32'h300
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [REGNO_W-1:0]      cmd_regno,
    input  logic [2:0]              cmd_size,
    input  logic                    cmd_transfer,
    input  logic                    cmd_write,
    input  logic                    cmd_postexec,
    input  logic [2:0]              err_in,
    input  logic                    csr_access_en,
    output logic [NUM_SLOTS*32-1:0] abuf_words,
    output logic                    done,
    output logic [2:0]              err_out
);
    localparam int               PTR_W     = $clog2(NUM_SLOTS + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(NUM_SLOTS - 1);

    gen_state_e       state_q, state_d;
    logic [2:0]       step_q, step_d;
    logic [PTR_W-1:0] wptr_q, wptr_d;
    logic [2:0]       err_q, err_d;
    reg_class_e       cls_in, cls_q;
    logic             fp_in, fp_q;
    logic [4:0]       idx_in, idx_q;
    logic [11:0]      csr_in, csr_q;
    logic             wr_q, post_q;
    logic             we, busy, accept;
    logic [31:0]      word;

    abs_reg_class #(.REGNO_W(REGNO_W)) u_cls (
        .regno    (cmd_regno),
        .csr_en   (csr_access_en),
        .rclass   (cls_in),
        .fp_side  (fp_in),
        .idx      (idx_in),
        .csr_addr (csr_in)
    );

    abs_word_sel #(
        .PTR_W(PTR_W), .DATA_OFS(DATA_OFS), .ABS_ADDR(ABS_ADDR), .PBUF_ADDR(PBUF_ADDR)
    ) u_sel (
        .state    (state_q),
        .step     (step_q),
        .rclass   (cls_q),
        .wr       (wr_q),
        .post     (post_q),
        .idx      (idx_q),
        .csr_addr (csr_q),
        .slot     (wptr_q),
        .word     (word)
    );

    abs_slot_buf #(.NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wptr  (wptr_q),
        .wdata (word),
        .words (abuf_words)
    );

    // output decode
    always_comb begin
        we   = 1'b0;
        done = 1'b0;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_PRO, ST_SAVE, ST_XFER, ST_REST, ST_EPI, ST_TERM, ST_FILL: we = 1'b1;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    assign accept  = cmd_valid && !busy;
    assign err_out = err_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        wptr_d  = we ? wptr_q + 1'b1 : wptr_q;
        err_d   = err_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    wptr_d = '0;
                    step_d = '0;
                    if (err_in != ERR_NONE) begin
                        err_d   = err_in;
                        state_d = ST_DONE;
                    end else if (!cmd_transfer) begin
                        err_d   = ERR_NONE;
                        state_d = ST_TERM;
                    end else if ((cmd_size != SIZE_32) || (cls_in == RC_BAD)) begin
                        err_d   = ERR_NOTSUP;
                        state_d = ST_DONE;
                    end else begin
                        err_d = ERR_NONE;
                        if (fp_in)                 state_d = ST_PRO;
                        else if (cls_in == RC_CSR) state_d = ST_SAVE;
                        else                       state_d = ST_XFER;
                    end
                end
            end
            ST_PRO: begin
                if (step_q == 3'd4) begin
                    step_d  = '0;
                    state_d = ST_XFER;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end
            ST_SAVE: begin
                step_d  = '0;
                state_d = ST_XFER;
            end
            ST_XFER: begin
                if ((cls_q != RC_CSR) || (step_q == 3'd1)) begin
                    step_d = '0;
                    if (fp_q)                 state_d = ST_EPI;
                    else if (cls_q == RC_CSR) state_d = ST_REST;
                    else                      state_d = ST_TERM;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end
            ST_REST: state_d = ST_TERM;
            ST_EPI: begin
                if (step_q == 3'd2) begin
                    step_d  = '0;
                    state_d = ST_TERM;
                end else begin
                    step_d = step_q + 3'd1;
                end
            end
            ST_TERM, ST_FILL: state_d = (wptr_q == LAST_SLOT) ? ST_DONE : ST_FILL;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            wptr_q  <= '0;
            err_q   <= ERR_NONE;
            cls_q   <= RC_GPR;
            fp_q    <= 1'b0;
            idx_q   <= '0;
            csr_q   <= '0;
            wr_q    <= 1'b0;
            post_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            wptr_q  <= wptr_d;
            err_q   <= err_d;
            if (accept) begin
                cls_q  <= cls_in;
                fp_q   <= fp_in;
                idx_q  <= idx_in;
                csr_q  <= csr_in;
                wr_q   <= cmd_write;
                post_q <= cmd_postexec;
            end
        end
    end
endmodule

// File: rtl/abs_gen_checker.sv
module abs_gen_checker #(
    parameter int BUF_W = 384
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             busy,
    input logic [2:0]       err_in,
    input logic             cmd_transfer,
    input logic [2:0]       cmd_size,
    input logic             done,
    input logic [2:0]       err_out,
    input logic [BUF_W-1:0] buf_flat
);
    logic        acc;
    logic [31:0] last_w;
    assign acc    = cmd_valid && !busy;
    assign last_w = buf_flat[BUF_W-1 -: 32];

    AST_ERR_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && err_in != 3'd0) |=> (done && err_out == $past(err_in))); // R1

    AST_ERR_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && err_in != 3'd0) |=> $stable(buf_flat)); // R1

    AST_SIZE_NOTSUP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && err_in == 3'd0 && cmd_transfer && cmd_size != 3'd2) |=> (done && err_out == 3'd2)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_LAST_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_out == 3'd0) |-> (last_w == 32'h0010_0073 || last_w[6:0] == 7'h6F)); // R10
endmodule

bind abs_cmd_gen abs_gen_checker #(.BUF_W(NUM_SLOTS*32)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .busy         (busy),
    .err_in       (err_in),
    .cmd_transfer (cmd_transfer),
    .cmd_size     (cmd_size),
    .done         (done),
    .err_out      (err_out),
    .buf_flat     (abuf_words)
);

// File: tb/sim_abs_cmd_gen.sv
`timescale 1ns/1ps
module sim_abs_cmd_gen;
    localparam int NS = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [15:0]   cmd_regno = '0;
    logic [2:0]    cmd_size = '0;
    logic          cmd_transfer = 1'b0;
    logic          cmd_write = 1'b0;
    logic          cmd_postexec = 1'b0;
    logic [2:0]    err_in = '0;
    logic          csr_access_en = 1'b0;
    logic [NS*32-1:0] abuf_words;
    logic          done;
    logic [2:0]    err_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_buf [NS];

    always #10 clk = ~clk;

    abs_cmd_gen u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_regno(cmd_regno),
        .cmd_size(cmd_size), .cmd_transfer(cmd_transfer), .cmd_write(cmd_write),
        .cmd_postexec(cmd_postexec), .err_in(err_in), .csr_access_en(csr_access_en),
        .abuf_words(abuf_words), .done(done), .err_out(err_out)
    );

    // reference encoders
    function automatic logic [31:0] m_csr(int f3, int rd, int rs1, int csr);
        return (32'(csr) << 20) | (32'(rs1) << 15) | (32'(f3) << 12) | (32'(rd) << 7) | 32'h73;
    endfunction
    function automatic logic [31:0] m_ld(int op, int rd);
        return (32'h380 << 20) | (32'd2 << 12) | (32'(rd) << 7) | 32'(op);
    endfunction
    function automatic logic [31:0] m_st(int op, int src);
        return ((32'h380 >> 5) << 25) | (32'(src) << 20) | (32'd2 << 12) | 32'(op);
    endfunction
    function automatic logic [31:0] m_jal(int slot);
        logic [31:0] d;
        d = 32'h300 - (32'h340 + 32'(4 * slot));
        return {d[20], d[10:1], d[11], d[19:12], 5'd0, 7'h6F};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_buf(input string req, input string tag);
        bit ok = 1;
        int bad = 0;
        for (int i = 0; i < NS; i++)
            if (ok && abuf_words[i*32 +: 32] !== exp_buf[i]) begin ok = 0; bad = i; end
        check(ok, req, $sformatf("%s slot %0d", tag, bad), abuf_words[bad*32 +: 32], exp_buf[bad]);
    endtask

    task automatic run(input logic [15:0] rn, input logic [2:0] sz, input logic tr, input logic wr,
                       input logic pe, input logic [2:0] ei, input logic ce,
                       input string req, input string tag);
        logic [31:0] q[$];
        logic [2:0]  xerr;
        bit          fp;
        int          lat;
        xerr = 3'd0;
        fp = (rn >= 16'h1020 && rn < 16'h1040) || rn == 16'h1 || rn == 16'h2 || rn == 16'h3;
        if (ei != 0) xerr = ei;
        else if (tr && (sz != 3'd2 || rn >= 16'h1040 || (rn < 16'h1000 && !ce))) xerr = 3'd2;
        if (xerr == 0) begin
            if (tr) begin
                if (fp) begin
                    q.push_back(m_csr(1, 0, 8, 'h7B2));
                    q.push_back(m_csr(2, 8, 0, 'h300));
                    q.push_back(m_csr(1, 0, 8, 'h7B3));
                    q.push_back(32'h0000_6437);
                    q.push_back(m_csr(2, 0, 8, 'h300));
                end
                if (rn < 16'h1000) begin
                    if (!fp) q.push_back(m_csr(1, 0, 8, 'h7B2));
                    if (wr) begin q.push_back(m_ld('h03, 8)); q.push_back(m_csr(1, 0, 8, int'(rn))); end
                    else    begin q.push_back(m_csr(2, 8, 0, int'(rn))); q.push_back(m_st('h23, 8)); end
                    if (!fp) q.push_back(m_csr(2, 8, 0, 'h7B2));
                end else if (rn < 16'h1020)
                    q.push_back(wr ? m_ld('h03, int'(rn[4:0])) : m_st('h23, int'(rn[4:0])));
                else
                    q.push_back(wr ? m_ld('h07, int'(rn[4:0])) : m_st('h27, int'(rn[4:0])));
                if (fp) begin
                    q.push_back(m_csr(2, 8, 0, 'h7B3));
                    q.push_back(m_csr(1, 0, 8, 'h300));
                    q.push_back(m_csr(2, 8, 0, 'h7B2));
                end
            end
            q.push_back(pe ? m_jal(q.size()) : 32'h0010_0073);
            while (q.size() < NS) q.push_back(32'h0010_0073);
        end
        lat = (xerr == 0) ? NS + 1 : 1;

        @(negedge clk);
        cmd_regno = rn; cmd_size = sz; cmd_transfer = tr; cmd_write = wr;
        cmd_postexec = pe; err_in = ei; csr_access_en = ce; cmd_valid = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1) cmd_valid = 1'b0;
            check(done === (k == lat), (xerr == 0) ? "R11" : req,
                  $sformatf("%s done cycle %0d", tag, k), {31'd0, done}, {31'd0, k == lat});
        end
        check(err_out === xerr, req, {tag, " err_out"}, {29'd0, err_out}, {29'd0, xerr});
        if (xerr == 0) for (int i = 0; i < NS; i++) exp_buf[i] = q[i];
        check_buf(req, tag);
        @(negedge clk);
        check(done === 1'b0, "R11", {tag, " done single"}, {31'd0, done}, 32'd0);
        err_in = 3'd0;
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) exp_buf[i] = 32'h0010_0073;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && err_out === 3'd0, "R12", "reset outputs",
              {28'd0, err_out, done}, 32'd0);
        check_buf("R12", "reset buffer");

        run(16'h1005, 3'd2, 1, 0, 0, 3'd0, 1, "R4",  "gpr read x5");
        run(16'h101F, 3'd2, 1, 1, 1, 3'd0, 0, "R4",  "gpr write x31 postexec R10");
        run(16'h1023, 3'd2, 1, 0, 0, 3'd0, 0, "R5",  "fpr read f3 R6");
        run(16'h103F, 3'd2, 1, 1, 1, 3'd0, 1, "R6",  "fpr write f31 R5 R10");
        run(16'h07C0, 3'd2, 1, 0, 0, 3'd0, 1, "R8",  "csr read R7");
        run(16'h0300, 3'd2, 1, 1, 1, 3'd0, 1, "R8",  "csr write R7 R10");
        run(16'h0003, 3'd2, 1, 0, 0, 3'd0, 1, "R7",  "fp csr read R5");
        run(16'h0001, 3'd2, 1, 1, 0, 3'd0, 1, "R7",  "fp csr write R6");
        run(16'h1001, 3'd3, 1, 0, 0, 3'd0, 1, "R3",  "size 64");
        run(16'h1001, 3'd1, 1, 1, 0, 3'd0, 1, "R3",  "size 16");
        run(16'h1040, 3'd2, 1, 0, 0, 3'd0, 1, "R2",  "regno past fpr");
        run(16'h07C0, 3'd2, 1, 0, 0, 3'd0, 0, "R2",  "csr disabled");
        run(16'h0002, 3'd2, 1, 0, 0, 3'd0, 0, "R2",  "fp csr disabled");
        run(16'h1005, 3'd2, 1, 0, 0, 3'd1, 1, "R1",  "pending error");
        run(16'hFFFF, 3'd5, 1, 0, 0, 3'd4, 1, "R1",  "pending error over bad cmd");
        run(16'hFFFF, 3'd7, 0, 0, 1, 3'd0, 0, "R9",  "no transfer postexec");
        run(16'h0000, 3'd0, 0, 1, 0, 3'd0, 0, "R9",  "no transfer ebreak");
        run(16'h1000, 3'd2, 1, 0, 1, 3'd0, 0, "R10", "x0 read jump");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule